// File: doc/BRIEF.md
# Variable-Rate Bit Gatherer With Slow-Domain Frame Handoff

This block sits behind an oversampling bit recoverer on a serial receive path. In each fast-clock cycle the recoverer delivers one, two or three freshly recovered bits, depending on how the sender's clock has drifted against the local one. The gatherer appends them in arrival order to a small window. It cuts the window into 5-bit sub-frames and pairs consecutive sub-frames into 10-bit frames. It then hands each frame to a slower clock domain by flipping a single toggle line.

A downstream framing search can ask the block to drop one extra bit in any cycle. Each drop moves the 10-bit boundary by one position, so that repeated drops walk through every possible alignment. Frames leave the fast side through two alternating frame banks. The slow side synchronizes the toggle and copies the bank that the toggle names. Each copied frame comes with a one-cycle strobe.

Top module: `bit_gatherer`

## Requirements
- R1: The bits appended in a cycle depend on the take flags. With `take_one` high, `bits_in[0]` alone is appended. Otherwise, with `take_three` high, `bits_in[2]`, `bits_in[1]` and `bits_in[0]` are appended in that order, and with neither flag high `bits_in[1]` then `bits_in[0]` are appended. `take_one` overrides `take_three`, and an unused `bits_in` bit has no effect.
- R2: While `skip_req` is high, the earliest-arriving bit of that cycle's group is discarded. `take_one` together with `skip_req` appends nothing, and the held state is left unchanged.
- R3: At the end of every cycle the window holds at most four bits. These are the newest bits that have not yet been emitted, so no bit is lost and none is repeated.
- R4: A sub-frame is emitted in exactly the cycles where held plus appended bits reach five. It contains the five oldest of those bits, with the oldest in sub-frame bit 4, and at most one sub-frame is emitted per cycle.
- R5: A two-state pairing machine starts in PAIR_LEAD. A sub-frame arriving in PAIR_LEAD is kept as the leading half, and the machine moves to PAIR_TRAIL. A sub-frame arriving in PAIR_TRAIL completes a frame, and the machine moves back to PAIR_LEAD. Without a sub-frame the state does not change. The leading half fills frame bits 9..5 and the trailing half fills bits 4..0, so frame bit 9 is the oldest bit.
- R6: The handoff toggle flips exactly once for each completed frame and holds its value in every other cycle.
- R7: A completed frame is written into the bank whose index equals the new toggle value. That bank is not written again until two further frames have completed.
- R8: On the slow side, the toggle passes through two flip-flops and is compared with a third, stored copy. When they differ, the bank named by the synchronized toggle is copied to `frame_out` and `frame_strobe` is raised for one slow cycle. `frame_out` changes only in cycles where `frame_strobe` is high.
- R9: After reset, the window is empty, the pairing machine is in PAIR_LEAD, the toggle is low, `frame_out` is zero and `frame_strobe` is low.
- R10: Every completed frame is delivered exactly once and in order. This holds as long as each toggle level lasts longer than one slow period and two frame intervals exceed three slow periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Bit-rate clock |
| rst_fast_n | input | 1 | Active-low asynchronous reset, fast domain |
| bits_in | input | 3 | Recovered bits, bit 2 earliest |
| take_one | input | 1 | Append only `bits_in[0]` this cycle |
| take_three | input | 1 | Append all three bits this cycle |
| skip_req | input | 1 | Drop the earliest incoming bit this cycle |
| clk_slow | input | 1 | Frame-rate clock |
| rst_slow_n | input | 1 | Active-low asynchronous reset, slow domain |
| frame_out | output | 10 | Delivered frame, bit 9 oldest |
| frame_strobe | output | 1 | One-cycle pulse when `frame_out` is updated |

## Verification
A bit drop and a sub-frame emission can fall in the same cycle. A three-bit take can also arrive when four bits are already held, which emits a sub-frame and keeps two bits in one step. The bench provokes these overlaps with sustained three-bit runs, with drops at a fixed cadence, and with an LFSR-driven mix of take and skip flags. It judges the result by rebuilding the expected frame sequence from its own record of the bits that should have been kept. Each delivered frame is compared in order against that sequence, and the number of frames is checked once the input has gone quiet.

// File: rtl/gath_pkg.sv
`timescale 1ns/1ps
package gath_pkg;
    typedef enum logic [0:0] {
        PAIR_LEAD  = 1'b0,
        PAIR_TRAIL = 1'b1
    } pair_state_e;
endpackage

// File: rtl/gath_accum.sv
`timescale 1ns/1ps
module gath_accum #(
    parameter int SUB_W    = 5,
    parameter int TAKE_MAX = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [TAKE_MAX-1:0] bits_in,
    input  logic                take_one,
    input  logic                take_three,
    input  logic                skip_req,
    output logic                sub_valid,
    output logic [SUB_W-1:0]    sub_data
);
    localparam int ACC_W = SUB_W + TAKE_MAX - 1;
    localparam int CNT_W = $clog2(ACC_W + 1);

    logic [ACC_W-1:0] acc_q, acc_d, merged, sub_word;
    logic [CNT_W-1:0] cnt_q, cnt_d, n_in, n_eff, total;

    // Merge the incoming group below the held bits; the oldest stays on the left.
    always_comb begin
        n_in = take_one ? CNT_W'(1) : (take_three ? CNT_W'(TAKE_MAX) : CNT_W'(TAKE_MAX - 1));
        n_eff = skip_req ? n_in - CNT_W'(1) : n_in;
        merged = (acc_q << n_eff)
               | (ACC_W'(bits_in) & ((ACC_W'(1) << n_eff) - ACC_W'(1)));
        total = cnt_q + n_eff;
        sub_valid = (total >= CNT_W'(SUB_W));
        cnt_d = sub_valid ? total - CNT_W'(SUB_W) : total;
        sub_word = merged >> (sub_valid ? total - CNT_W'(SUB_W) : CNT_W'(0));
        sub_data = sub_word[SUB_W-1:0];
        acc_d = merged & ((ACC_W'(1) << cnt_d) - ACC_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else begin
            acc_q <= acc_d;
            cnt_q <= cnt_d;
        end
    end

    p_hold_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(SUB_W - 1));

    p_single_take_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (take_one && !skip_req && cnt_q < CNT_W'(SUB_W - 1))
        |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    p_skip_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (take_one && skip_req) |-> !sub_valid);

    p_skip_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (take_one && skip_req) |=> ($stable(cnt_q) && $stable(acc_q)));

    p_drain_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sub_valid |=> (cnt_q < CNT_W'(TAKE_MAX)));
endmodule

// File: rtl/gath_pair.sv
`timescale 1ns/1ps
module gath_pair
    import gath_pkg::*;
#(
    parameter int SUB_W = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sub_valid,
    input  logic [SUB_W-1:0]            sub_data,
    output logic                        hand_tgl,
    output logic [1:0][2*SUB_W-1:0]     banks
);
    localparam int FRAME_W = 2 * SUB_W;

    pair_state_e      state_q, state_d;
    logic             frame_done;
    logic [SUB_W-1:0] lead_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PAIR_LEAD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d    = state_q;
        frame_done = 1'b0;
        unique case (state_q)
            PAIR_LEAD:  if (sub_valid) state_d = PAIR_TRAIL;
            PAIR_TRAIL: if (sub_valid) begin
                state_d    = PAIR_LEAD;
                frame_done = 1'b1;
            end
        endcase
    end

    // Output process: leading half, toggle and the two frame banks.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lead_q   <= '0;
            hand_tgl <= 1'b0;
        end else begin
            if (state_q == PAIR_LEAD && sub_valid) lead_q <= sub_data;
            if (frame_done) hand_tgl <= ~hand_tgl;
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_bank
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                banks[g] <= '0;
            else if (frame_done && (hand_tgl != 1'(g)))
                banks[g] <= {lead_q, sub_data};
        end
    end

    p_lead_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PAIR_LEAD && sub_valid) |=> (state_q == PAIR_TRAIL && $stable(hand_tgl)));

    p_pair_content_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PAIR_TRAIL && sub_valid)
        |=> (banks[hand_tgl][SUB_W-1:0] == $past(sub_data)
             && banks[hand_tgl][FRAME_W-1:SUB_W] == $past(lead_q)));

    p_flip_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PAIR_TRAIL && sub_valid) |=> (hand_tgl != $past(hand_tgl)));

    p_tgl_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(state_q == PAIR_TRAIL && sub_valid) |=> $stable(hand_tgl));

    p_bank_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sub_valid |=> $stable(banks));
endmodule

// File: rtl/gath_handoff.sv
`timescale 1ns/1ps
module gath_handoff #(
    parameter int FRAME_W = 10,
    parameter int SYNC_N  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tgl_in,
    input  logic [1:0][FRAME_W-1:0] banks_in,
    output logic [FRAME_W-1:0]      frame_out,
    output logic                    frame_strobe
);
    // chain[SYNC_N-1:0] are the synchronizer stages, chain[SYNC_N] the stored copy.
    logic [SYNC_N:0] chain;
    logic            tgl_edge;
    logic            sel;

    assign tgl_edge = chain[SYNC_N] ^ chain[SYNC_N-1];
    assign sel      = chain[SYNC_N-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain        <= '0;
            frame_out    <= '0;
            frame_strobe <= 1'b0;
        end else begin
            chain        <= {chain[SYNC_N-1:0], tgl_in};
            frame_strobe <= tgl_edge;
            if (tgl_edge) frame_out <= banks_in[sel];
        end
    end

    p_quiet_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_strobe |-> $stable(frame_out));
endmodule

// File: rtl/bit_gatherer.sv
`timescale 1ns/1ps
module bit_gatherer #(
    parameter int SUB_W    = 5,
    parameter int TAKE_MAX = 3,
    parameter int SYNC_N   = 2
) (
    input  logic                 clk_fast,
    input  logic                 rst_fast_n,
    input  logic [TAKE_MAX-1:0]  bits_in,
    input  logic                 take_one,
    input  logic                 take_three,
    input  logic                 skip_req,
    input  logic                 clk_slow,
    input  logic                 rst_slow_n,
    output logic [2*SUB_W-1:0]   frame_out,
    output logic                 frame_strobe
);
    localparam int FRAME_W = 2 * SUB_W;

    logic                    sub_valid;
    logic [SUB_W-1:0]        sub_data;
    logic                    hand_tgl;
    logic [1:0][FRAME_W-1:0] banks;

    gath_accum #(.SUB_W(SUB_W), .TAKE_MAX(TAKE_MAX)) u_accum (
        .clk        (clk_fast),
        .rst_n      (rst_fast_n),
        .bits_in    (bits_in),
        .take_one   (take_one),
        .take_three (take_three),
        .skip_req   (skip_req),
        .sub_valid  (sub_valid),
        .sub_data   (sub_data)
    );

    gath_pair #(.SUB_W(SUB_W)) u_pair (
        .clk       (clk_fast),
        .rst_n     (rst_fast_n),
        .sub_valid (sub_valid),
        .sub_data  (sub_data),
        .hand_tgl  (hand_tgl),
        .banks     (banks)
    );

    gath_handoff #(.FRAME_W(FRAME_W), .SYNC_N(SYNC_N)) u_handoff (
        .clk          (clk_slow),
        .rst_n        (rst_slow_n),
        .tgl_in       (hand_tgl),
        .banks_in     (banks),
        .frame_out    (frame_out),
        .frame_strobe (frame_strobe)
    );
endmodule

// File: tb/bit_gatherer_test.sv
`timescale 1ns/1ps
module bit_gatherer_test;
    logic       clk_fast   = 1'b0;
    logic       clk_slow   = 1'b0;
    logic       rst_fast_n = 1'b0;
    logic       rst_slow_n = 1'b0;
    logic [2:0] bits_in    = '0;
    logic       take_one   = 1'b1;
    logic       take_three = 1'b0;
    logic       skip_req   = 1'b1;
    logic [9:0] frame_out;
    logic       frame_strobe;

    int checks = 0;
    int fails  = 0;
    bit exp_bits [0:8191];
    int wr_idx = 0;
    int rx_idx = 0;
    logic [15:0] lf = 16'hACE1;

    bit_gatherer uut (
        .clk_fast     (clk_fast),
        .rst_fast_n   (rst_fast_n),
        .bits_in      (bits_in),
        .take_one     (take_one),
        .take_three   (take_three),
        .skip_req     (skip_req),
        .clk_slow     (clk_slow),
        .rst_slow_n   (rst_slow_n),
        .frame_out    (frame_out),
        .frame_strobe (frame_strobe)
    );

    always #2 clk_fast = ~clk_fast;           // 250 MHz
    initial begin
        #0.5;
        forever #3 clk_slow = ~clk_slow;
    end

    // Slow-side monitor: each strobe must carry the next expected frame (R10, R5, R8).
    always @(negedge clk_slow) begin
        if (rst_slow_n && frame_strobe) begin
            logic [9:0] e;
            e = '0;
            checks++;
            if (rx_idx * 10 + 9 >= wr_idx) begin
                fails++;
                $display("FAIL R10 unexpected frame %0d: got %b expected none (%0d bits kept)",
                         rx_idx, frame_out, wr_idx);
            end else begin
                for (int i = 0; i < 10; i++) e[9-i] = exp_bits[rx_idx*10 + i];
                if (frame_out !== e) begin
                    fails++;
                    $display("FAIL R10 frame %0d: got %b expected %b", rx_idx, frame_out, e);
                end
            end
            rx_idx++;
        end
    end

    // Drive one cycle and record the bits that must be kept (R1, R2).
    task automatic drive(input logic [2:0] b, input logic t1, input logic t3, input logic sk);
        int n;
        @(negedge clk_fast);
        bits_in = b; take_one = t1; take_three = t3; skip_req = sk;
        n = t1 ? 1 : (t3 ? 3 : 2);
        for (int i = n - 1; i >= 0; i--) begin
            if (!(sk && i == n - 1) && wr_idx < 8192) begin
                exp_bits[wr_idx] = b[i];
                wr_idx++;
            end
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) drive(3'b111, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic settle_check(input string tag);
        idle(30);
        checks++;
        if (rx_idx != wr_idx / 10) begin
            fails++;
            $display("FAIL %s frame count: got %0d expected %0d", tag, rx_idx, wr_idx / 10);
        end
    endtask

    task automatic do_reset();
        @(negedge clk_fast);
        rst_fast_n = 1'b0; rst_slow_n = 1'b0;
        bits_in = '0; take_one = 1'b1; take_three = 1'b0; skip_req = 1'b1;
        repeat (4) @(negedge clk_fast);
        wr_idx = 0; rx_idx = 0;
        rst_fast_n = 1'b1; rst_slow_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk_slow);
        checks++;
        if (frame_strobe !== 1'b0 || frame_out !== 10'd0) begin
            fails++;
            $display("FAIL R9 reset outputs: got strobe=%b frame=%b expected 0/0000000000",
                     frame_strobe, frame_out);
        end
        idle(40);   // R2: zero-bit cycles must produce nothing
        checks++;
        if (rx_idx != 0 || frame_out !== 10'd0) begin
            fails++;
            $display("FAIL R2 idle produced frames: got %0d frame=%b expected 0", rx_idx, frame_out);
        end
        settle_check("R9");
    endtask

    task automatic t_steady();
        logic [19:0] pat;
        do_reset();
        pat = 20'b00111110101100000101;
        for (int c = 0; c < 60; c++) begin
            int p;
            p = (c * 2) % 20;
            drive({1'b0, pat[19-p], pat[18-p]}, 1'b0, 1'b0, 1'b0);
        end
        settle_check("R3 steady");
    endtask

    task automatic t_single();
        do_reset();
        for (int c = 0; c < 40; c++) drive({2'(c), 1'(c % 3 == 0)}, 1'b1, 1'b0, 1'b0);
        settle_check("R1 single");
    endtask

    task automatic t_triple();
        do_reset();
        drive(3'b010, 1'b0, 1'b0, 1'b0);
        for (int c = 0; c < 40; c++) drive(3'(c * 5 + 3), 1'b0, 1'b1, 1'b0);
        settle_check("R4 triple");
    endtask

    task automatic t_conflict();
        do_reset();
        for (int c = 0; c < 30; c++) drive(3'(c * 3 + 1), 1'b1, 1'b1, 1'b0);
        settle_check("R1 conflict");
    endtask

    task automatic t_skip();
        do_reset();
        for (int c = 0; c < 70; c++) begin
            logic t1, t3;
            t1 = (c % 11 == 4);
            t3 = (c % 5 == 2);
            drive(3'(c * 7 + 2), t1, t3, (c % 7 == 3) || (c % 13 == 0));
        end
        settle_check("R2 skip");
    endtask

    task automatic t_mixed();
        do_reset();
        for (int c = 0; c < 500; c++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            drive(lf[10:8], lf[2:0] == 3'd0, lf[2:0] == 3'd1, lf[7:4] == 4'd0);
        end
        settle_check("R6 R7 R8 mixed");
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_steady();
        t_single();
        t_triple();
        t_conflict();
        t_skip();
        t_mixed();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule